// File: doc/BRIEF.md
# Window Comparator Interrupt Unit

The unit watches four converter channels. Each time a channel delivers a new 10-bit sample with its valid strobe, the upper eight bits of that sample are compared against the channel's programmable high limit and low limit. A value above the high limit or below the low limit latches a sticky flag. Each channel has one high flag and one low flag. The flags together form an 8-bit flag register.

Reading the flag register is signalled by a one-cycle read strobe, and that read clears every flag. A limit programmed to zero is switched off: its flag never sets and it cannot raise the interrupt. The interrupt goes to a shared open-drain pad. The unit only asks for the pad to be pulled low, and releases the pad otherwise, so several peripherals can share one active-low request line.

Top module: `wcmp_irq_unit`

## Requirements
- R1: The value compared for channel k is bits [9:2] of that channel's 10-bit sample; bits [1:0] never affect a flag.
- R2: A valid sample whose upper byte is strictly greater than a nonzero high limit sets that channel's high flag on the next clock edge; an equal value does not set it.
- R3: A valid sample whose upper byte is strictly less than a nonzero low limit sets that channel's low flag on the next clock edge; an equal value does not set it.
- R4: Flag bit 2k+1 is the high flag of channel k and bit 2k is its low flag, for k = 0..3 (channel 0 in bits 1:0, channel 3 in bits 7:6).
- R5: A set flag stays set while no read strobe occurs, including when later samples fall back inside the window.
- R6: A read strobe clears all flags at the next edge, except a flag that a valid out-of-window sample sets in that same cycle, which stays set.
- R7: A limit equal to zero never sets its flag, and a set flag whose limit is now zero does not hold the interrupt.
- R8: irq_pull_o is 1 exactly when some flag is set and its limit is nonzero; it returns to 0 in the cycle after a read that clears every flag.
- R9: While rst_ni is low and after reset, all flags are 0 and irq_pull_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 40 | Four 10-bit samples, channel k at bits [10k+9:10k] |
| sample_vld_i | input | 4 | Per-channel strobe marking a new sample |
| hi_lim_i | input | 32 | Four 8-bit high limits, channel k at bits [8k+7:8k] |
| lo_lim_i | input | 32 | Four 8-bit low limits, channel k at bits [8k+7:8k] |
| flag_rd_i | input | 1 | Flag register read strobe (clears flags) |
| flags_o | output | 8 | Sticky flag register, layout per R4 |
| irq_pull_o | output | 1 | 1: pull the shared active-low interrupt pad to 0; 0: release it |

## Verification
The assertions check several rules on every cycle. Flags never appear without a valid strobe. They persist while no read occurs and vanish after a read that has no competing sample. An out-of-window sample against a nonzero limit always lands in the right bit. The interrupt request is low whenever no flag is set or every limit is zero. Some behaviours are shown only by the bench scenarios. These are the equality boundaries at the limits, the insensitivity to the two discarded low bits, and a set flag losing its interrupt when its limit is rewritten to zero. They also include a read that coincides with a new out-of-window sample.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  localparam int unsigned CMP_W = 8;

  // flag bit index of a channel's high or low flag
  function automatic int unsigned flag_idx(input int unsigned ch, input bit is_hi);
    return 2 * ch + (is_hi ? 1 : 0);
  endfunction
endpackage

// File: rtl/wcmp_chan.sv
module wcmp_chan #(
  parameter int unsigned SW = 10,
  parameter int unsigned LW = wcmp_pkg::CMP_W
) (
  input  logic [SW-1:0] sample_i,
  input  logic          vld_i,
  input  logic [LW-1:0] hi_lim_i,
  input  logic [LW-1:0] lo_lim_i,
  output logic          hit_hi_o,
  output logic          hit_lo_o,
  output logic          en_hi_o,
  output logic          en_lo_o
);
  logic [LW-1:0] top_bits;

  assign top_bits = sample_i[SW-1 -: LW];
  assign en_hi_o  = |hi_lim_i;
  assign en_lo_o  = |lo_lim_i;
  assign hit_hi_o = vld_i && en_hi_o && (top_bits > hi_lim_i);
  assign hit_lo_o = vld_i && en_lo_o && (top_bits < lo_lim_i);
endmodule

// File: rtl/wcmp_flags.sv
module wcmp_flags #(
  parameter int unsigned FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] set_i,
  input  logic          rd_i,
  output logic [FW-1:0] flags_o
);
  logic [FW-1:0] flags_q;

  // new hits win over the clear from a coincident read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (rd_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/wcmp_irq.sv
module wcmp_irq #(
  parameter int unsigned FW = 8
) (
  input  logic [FW-1:0] flags_i,
  input  logic [FW-1:0] en_i,
  output logic          pull_o
);
  assign pull_o = |(flags_i & en_i);
endmodule

// File: rtl/wcmp_irq_unit.sv
module wcmp_irq_unit #(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 10,
  parameter int unsigned LW  = wcmp_pkg::CMP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*SW-1:0] sample_i,
  input  logic [NCH-1:0]    sample_vld_i,
  input  logic [NCH*LW-1:0] hi_lim_i,
  input  logic [NCH*LW-1:0] lo_lim_i,
  input  logic              flag_rd_i,
  output logic [2*NCH-1:0]  flags_o,
  output logic              irq_pull_o
);
  localparam int unsigned FW = 2 * NCH;

  logic [FW-1:0] hit;
  logic [FW-1:0] en;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    wcmp_chan #(.SW(SW), .LW(LW)) i_chan (
      .sample_i (sample_i[k*SW +: SW]),
      .vld_i    (sample_vld_i[k]),
      .hi_lim_i (hi_lim_i[k*LW +: LW]),
      .lo_lim_i (lo_lim_i[k*LW +: LW]),
      .hit_hi_o (hit[wcmp_pkg::flag_idx(k, 1'b1)]),
      .hit_lo_o (hit[wcmp_pkg::flag_idx(k, 1'b0)]),
      .en_hi_o  (en[wcmp_pkg::flag_idx(k, 1'b1)]),
      .en_lo_o  (en[wcmp_pkg::flag_idx(k, 1'b0)])
    );
  end

  wcmp_flags #(.FW(FW)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hit),
    .rd_i    (flag_rd_i),
    .flags_o (flags_o)
  );

  wcmp_irq #(.FW(FW)) i_irq (
    .flags_i (flags_o),
    .en_i    (en),
    .pull_o  (irq_pull_o)
  );
endmodule

// File: rtl/wcmp_irq_unit_chk.sv
module wcmp_irq_unit_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 10,
  parameter int unsigned LW  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH*SW-1:0] sample_i,
  input logic [NCH-1:0]    sample_vld_i,
  input logic [NCH*LW-1:0] hi_lim_i,
  input logic [NCH*LW-1:0] lo_lim_i,
  input logic              flag_rd_i,
  input logic [2*NCH-1:0]  flags_o,
  input logic              irq_pull_o
);
  AST_NO_SET_WITHOUT_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_vld_i == '0) |=> ((flags_o & ~$past(flags_o)) == '0)); // R2

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R5

  AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && sample_vld_i == '0) |=> (flags_o == '0)); // R6

  AST_IDLE_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o == '0) |-> !irq_pull_o); // R8

  AST_ALL_OFF_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_lim_i == '0 && lo_lim_i == '0) |-> !irq_pull_o); // R7

  for (genvar k = 0; k < NCH; k++) begin : g_a
    AST_HI_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sample_vld_i[k] && hi_lim_i[k*LW +: LW] != '0 &&
       sample_i[k*SW+SW-1 -: LW] > hi_lim_i[k*LW +: LW]) |=> flags_o[2*k+1]); // R4
    AST_LO_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sample_vld_i[k] && lo_lim_i[k*LW +: LW] != '0 &&
       sample_i[k*SW+SW-1 -: LW] < lo_lim_i[k*LW +: LW]) |=> flags_o[2*k]); // R3
  end
endmodule

bind wcmp_irq_unit wcmp_irq_unit_chk #(.NCH(NCH), .SW(SW), .LW(LW)) i_chk (.*);

// File: tb/test_wcmp_irq_unit.sv
`timescale 1ns/1ps
module test_wcmp_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  smp [4];
  logic [7:0]  hl  [4];
  logic [7:0]  ll  [4];
  logic [3:0]  vld = '0;
  logic        rd = 1'b0;
  logic [39:0] sample_flat;
  logic [31:0] hi_flat, lo_flat;
  logic [7:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R9";
  logic [7:0] mflags;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      sample_flat[k*10 +: 10] = smp[k];
      hi_flat[k*8 +: 8] = hl[k];
      lo_flat[k*8 +: 8] = ll[k];
    end
  end

  wcmp_irq_unit i_wcmp_irq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_flat), .sample_vld_i(vld),
    .hi_lim_i(hi_flat), .lo_lim_i(lo_flat), .flag_rd_i(rd),
    .flags_o(flags), .irq_pull_o(irq)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mflags <= 8'h00;
    else begin
      logic [7:0] nx;
      nx = rd ? 8'h00 : mflags;
      for (int k = 0; k < 4; k++) begin
        int top;
        top = int'(smp[k]) / 4;
        if (vld[k] && hl[k] != 0 && top > int'(hl[k])) nx[2*k+1] = 1'b1;
        if (vld[k] && ll[k] != 0 && top < int'(ll[k])) nx[2*k]   = 1'b1;
      end
      mflags <= nx;
    end
  end

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (mflags[2*k+1] && hl[k] != 0) r = 1'b1;
      if (mflags[2*k]   && ll[k] != 0) r = 1'b1;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (flags !== mflags || irq !== model_irq()) begin
        errors++;
        $display("FAIL %s cycle compare: flags=%h irq=%b expected flags=%h irq=%b",
                 cur_req, flags, irq, mflags, model_irq());
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] ef, input logic ei);
    checks++;
    if (flags !== ef || irq !== ei) begin
      errors++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, ef, ei);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #3;
    vld = '0; rd = 1'b0;
  endtask

  task automatic put(input int ch, input int val);
    smp[ch] = 10'(val); vld[ch] = 1'b1;
  endtask

  task automatic do_read();
    rd = 1'b1; cyc();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin smp[k] = '0; hl[k] = '0; ll[k] = '0; end
    #12;
    chk("R9", 8'h00, 1'b0);
    rst_ni = 1'b1;
    @(posedge clk); #3;
    chk("R9", 8'h00, 1'b0);

    // R1/R2: equal upper byte with nonzero low bits does not set
    cur_req = "R2";
    hl[0] = 8'd100; ll[0] = 8'd50;
    put(0, (100 << 2) | 3); cyc();
    chk("R1", 8'h00, 1'b0);
    put(0, (101 << 2)); cyc();
    chk("R2", 8'h02, 1'b1);

    // R5: inside-window sample leaves it set
    cur_req = "R5";
    put(0, 75 << 2); cyc();
    chk("R5", 8'h02, 1'b1);
    cyc(); cyc();
    chk("R5", 8'h02, 1'b1);

    // R6/R8: read clears and releases
    cur_req = "R6";
    do_read();
    chk("R8", 8'h00, 1'b0);

    // R3: equal low does not set, below does
    cur_req = "R3";
    put(0, 50 << 2); cyc();
    chk("R3", 8'h00, 1'b0);
    put(0, (49 << 2) | 3); cyc();
    chk("R3", 8'h01, 1'b1);

    // R4: layout across channels
    cur_req = "R4";
    hl[2] = 8'd10; ll[3] = 8'd200; hl[1] = 8'd30; ll[1] = 8'd20;
    put(2, 11 << 2); put(3, 199 << 2); cyc();
    chk("R4", 8'h61, 1'b1);
    put(1, 19 << 2); cyc();
    chk("R4", 8'h65, 1'b1);
    put(1, 31 << 2); cyc();
    chk("R4", 8'h6D, 1'b1);

    // R6: read coinciding with a new hit keeps the new hit
    cur_req = "R6";
    put(2, 255 << 2); rd = 1'b1; cyc();
    chk("R6", 8'h20, 1'b1);
    do_read();
    chk("R6", 8'h00, 1'b0);

    // R7: zero limits never set
    cur_req = "R7";
    hl[3] = 8'd0; ll[3] = 8'd0;
    put(3, 1023); cyc();
    chk("R7", 8'h00, 1'b0);
    put(3, 0); cyc();
    chk("R7", 8'h00, 1'b0);

    // R7: flag whose limit goes to zero stops holding the interrupt
    put(1, 200 << 2); cyc();
    chk("R7", 8'h08, 1'b1);
    hl[1] = 8'd0; #1;
    chk("R7", 8'h08, 1'b0);
    hl[1] = 8'd30; #1;
    chk("R8", 8'h08, 1'b1);
    do_read();
    chk("R8", 8'h00, 1'b0);

    // R9: asynchronous reset clears flags
    cur_req = "R9";
    put(0, 1023); cyc();
    chk("R2", 8'h02, 1'b1);
    rst_ni = 1'b0; #1;
    chk("R9", 8'h00, 1'b0);
    @(posedge clk); #3;
    rst_ni = 1'b1;
    cyc();
    chk("R9", 8'h00, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule